// File: doc/BRIEF.md
# Packed-Lane Saturating Add, Subtract and Absolute Unit

This unit works on 64-bit words split into independent signed lanes. Per operation it performs a signed add, a signed subtract (first operand minus second), or an absolute value of the first operand. It runs on every lane at once, and each lane result is clamped into that lane's signed range. A size select picks either eight lanes of 8 bits or four lanes of 16 bits. No carry or borrow ever crosses from one lane into the next.

Each accepted operation produces a registered result one clock later, with a matching valid strobe. It also produces a per-operation overflow bit, which is high when any lane had to be clamped. A sticky overflow flag gathers these bits across operations. Only a dedicated clear input resets it, so software-style code can run a batch of operations and test one flag at the end.

Top module: `simd_sat_alu`

## Requirements
- R1: With opcode 2'b10 (absolute value), a lane whose sign bit is set yields its two's-complement negation, and a non-negative lane passes unchanged. The second operand is ignored.
- R2: With opcode 2'b10, a lane equal to the most negative value (0x80 in 8-bit lanes, 0x8000 in 16-bit lanes) yields the most positive value (0x7F or 0x7FFF) and raises the overflow bit.
- R3: With opcode 2'b00 (add), each lane gives a+b at full precision, clamped to 127/-128 (8-bit) or 32767/-32768 (16-bit).
- R4: With opcode 2'b01 (subtract), each lane gives a-b, clamped to the same signed lane range as R3.
- R5: With lane_16 = 0, lane k occupies bits [8k+7:8k] (k = 0..7). With lane_16 = 1, lane k occupies bits [16k+15:16k] (k = 0..3). Lanes never pass a carry to one another.
- R6: Opcode 2'b11 yields an all-zero result and no overflow.
- R7: op_ovf, registered alongside the result, is 1 exactly when at least one lane of that operation was clamped.
- R8: ovf_sticky is set by every operation whose op_ovf is 1 and stays set until ovf_clear is pulsed. When a clear and an overflowing operation are presented in the same cycle, the flag ends up set.
- R9: result, op_ovf and out_valid change one clock after an in_valid cycle. out_valid is high for exactly that one cycle. Without in_valid, result and op_ovf hold their values.
- R10: While reset is asserted, out_valid, result, op_ovf and ovf_sticky are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 absolute, 11 zero |
| lane_16 | input | 1 | 0: eight 8-bit lanes, 1: four 16-bit lanes |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand (unused by absolute) |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Packed clamped result |
| op_ovf | output | 1 | Some lane of the last operation was clamped |
| ovf_sticky | output | 1 | Accumulated overflow since the last clear |

## Verification
The hardest situation to reach is the collision between a clear and an overflowing operation in the same cycle. That case decides whether the flag loses an event. The bench builds it on purpose by raising ovf_clear on the same edge as an add that clamps. It also checks the plain clear and the plain set separately. The lane-boundary behaviour is forced by applying one operand pair in both lane sizes, where a carry that 16-bit lanes propagate must vanish in 8-bit lanes. The absolute-value corner is placed in lanes other than lane 0.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_ABS  = 2'b10,
    OP_ZERO = 2'b11
  } sat_op_e;

endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
  parameter int W = 8
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         sat
);
  import simd_sat_pkg::*;

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // One bit of headroom: every add/sub/abs result fits in W+1 bits.
  function automatic logic [W:0] widened(input logic [1:0] o,
                                         input logic [W-1:0] x,
                                         input logic [W-1:0] z);
    logic [W:0] xe, ze;
    xe = {x[W-1], x};
    ze = {z[W-1], z};
    case (o)
      OP_ADD:  widened = xe + ze;
      OP_SUB:  widened = xe - ze;
      OP_ABS:  widened = x[W-1] ? (~xe + 1'b1) : xe;
      default: widened = '0;
    endcase
  endfunction

  // Out of range exactly when the two top bits disagree.
  function automatic logic beyond(input logic [W:0] v);
    beyond = v[W] ^ v[W-1];
  endfunction

  function automatic logic [W-1:0] clamp(input logic [W:0] v);
    if (beyond(v)) clamp = v[W] ? MINV : MAXV;
    else           clamp = v[W-1:0];
  endfunction

  logic [W:0] wide;

  always_comb begin
    wide = widened(op, a, b);
    y    = clamp(wide);
    sat  = beyond(wide);
  end

  // R1/R2: an absolute result is never negative.
  always_comb begin
    if (op == OP_ABS) begin
      p_abs_nonneg_r1: assert (!y[W-1]);
    end
  end

endmodule

// File: rtl/sat_lane_group.sv
module sat_lane_group #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              any_sat
);
  localparam int N_LANES = DATA_W / LANE_W;

  logic [N_LANES-1:0] lane_sat;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    sat_lane #(.W(LANE_W)) i_lane (
      .op  (op),
      .a   (a[k*LANE_W +: LANE_W]),
      .b   (b[k*LANE_W +: LANE_W]),
      .y   (y[k*LANE_W +: LANE_W]),
      .sat (lane_sat[k])
    );
  end

  assign any_sat = |lane_sat;

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              lane_16,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              ovf_clear,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              op_ovf,
  output logic              ovf_sticky
);
  import simd_sat_pkg::*;

  logic [DATA_W-1:0] narrow_y, wide_y, sel_y;
  logic              narrow_sat, wide_sat;
  logic              lane_ovf;     // any lane clamped this cycle
  logic              ovf_event;    // accepted operation that clamped

  sat_lane_group #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) i_narrow (
    .op(op), .a(src_a), .b(src_b), .y(narrow_y), .any_sat(narrow_sat)
  );

  sat_lane_group #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) i_wide (
    .op(op), .a(src_a), .b(src_b), .y(wide_y), .any_sat(wide_sat)
  );

  assign sel_y     = lane_16 ? wide_y : narrow_y;
  assign lane_ovf  = lane_16 ? wide_sat : narrow_sat;
  assign ovf_event = in_valid & lane_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      op_ovf     <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      if (in_valid) begin
        result <= sel_y;
        op_ovf <= lane_ovf;
      end
      ovf_sticky <= (ovf_sticky & ~ovf_clear) | ovf_event;
    end
  end

  // R9: valid travels with the data, one cycle late
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(op_ovf)));

  // R6: the unused opcode produces zero without overflow
  p_zero_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ZERO) |=> (result == '0 && !op_ovf));

  // R8: sticky keeps its value until cleared, and sees every overflow
  p_sticky_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clear) |=> ovf_sticky);
  p_sticky_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clear && !ovf_event) |=> !ovf_sticky);
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_ovf) |-> ovf_sticky);

endmodule

// File: tb/test_simd_sat_alu.sv
`timescale 1ns/1ps
module test_simd_sat_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        lane_16 = 1'b0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        ovf_clear = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        op_ovf;
  logic        ovf_sticky;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd_sat_alu i_simd_sat_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_16(lane_16),
    .src_a(src_a), .src_b(src_b), .ovf_clear(ovf_clear),
    .out_valid(out_valid), .result(result), .op_ovf(op_ovf), .ovf_sticky(ovf_sticky)
  );

  // {op, lane_16, a, b, expected, expected overflow}
  localparam int NV = 13;
  localparam logic [195:0] VEC [NV] = '{
    {2'b00, 1'b0, 64'h7F80_10F0_01FF_40C0, 64'h01FF_20F0_0101_40C0, 64'h7F80_30E0_0200_7F80, 1'b1},
    {2'b00, 1'b1, 64'h7F80_10F0_01FF_40C0, 64'h01FF_20F0_0101_40C0, 64'h7FFF_31E0_0300_7FFF, 1'b1},
    {2'b00, 1'b0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 64'h1112_1314_1516_1718, 1'b0},
    {2'b01, 1'b0, 64'h807F_0010_F005_0080, 64'h01FF_8020_1005_7F80, 64'h807F_7FF0_E000_8100, 1'b1},
    {2'b01, 1'b1, 64'h8000_7FFF_1234_0000, 64'h0001_FFFF_0234_8000, 64'h8000_7FFF_1000_7FFF, 1'b1},
    {2'b01, 1'b1, 64'h0005_FFFF_0100_8000, 64'h0003_0001_0200_FFFF, 64'h0002_FFFE_FF00_8001, 1'b0},
    {2'b10, 1'b0, 64'h807F_FF01_00C0_813C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7F7F_0101_0040_7F3C, 1'b1},
    {2'b10, 1'b0, 64'hFE02_9070_00FF_8101, 64'h8080_8080_8080_8080, 64'h0202_7070_0001_7F01, 1'b0},
    {2'b10, 1'b1, 64'h8000_FFFF_0080_8001, 64'h0000_0000_0000_0000, 64'h7FFF_0001_0080_7FFF, 1'b1},
    {2'b10, 1'b1, 64'hFF80_0001_C000_7FFF, 64'h1234_5678_9ABC_DEF0, 64'h0080_0001_4000_7FFF, 1'b0},
    {2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0000_0000_0000_0000, 1'b0},
    {2'b00, 1'b1, 64'h00FF_00FF_7FFF_FFFF, 64'h0001_0001_0000_0001, 64'h0100_0100_7FFF_0000, 1'b0},
    {2'b00, 1'b0, 64'h00FF_00FF_7FFF_FFFF, 64'h0001_0001_0000_0001, 64'h0000_0000_7FFF_FF00, 1'b0}
  };

  function automatic string tag_for(int i);
    case (i)
      0, 1, 2:  tag_for = "R3";
      3, 4, 5:  tag_for = "R4";
      6, 8:     tag_for = "R2";
      7, 9:     tag_for = "R1";
      10:       tag_for = "R6";
      default:  tag_for = "R5";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] o, logic l16, logic [63:0] a, logic [63:0] b, logic clr);
    @(negedge clk);
    op = o; lane_16 = l16; src_a = a; src_b = b; in_valid = 1'b1; ovf_clear = clr;
    @(negedge clk);
    in_valid = 1'b0; ovf_clear = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 result", result, 64'd0);
    check("R10 op_ovf", {63'd0, op_ovf}, 64'd0);
    check("R10 ovf_sticky", {63'd0, ovf_sticky}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][195:194], VEC[i][193], VEC[i][192:129], VEC[i][128:65], 1'b0);
      check({tag_for(i), " result"}, result, VEC[i][64:1]);
      check("R7 op_ovf", {63'd0, op_ovf}, {63'd0, VEC[i][0]});
      check("R9 out_valid", {63'd0, out_valid}, 64'd1);
    end

    // R9: one-cycle valid, hold without in_valid even as inputs change
    @(negedge clk);
    src_a = 64'h8080_8080_8080_8080; src_b = 64'h8080_8080_8080_8080; op = 2'b00;
    check("R9 valid drops", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R9 result held", result, 64'h0000_0000_7FFF_FF00);
    check("R9 op_ovf held", {63'd0, op_ovf}, 64'd0);

    // R8: sticky set by earlier vectors, then cleared
    check("R8 sticky accumulated", {63'd0, ovf_sticky}, 64'd1);
    pulse_clear();
    check("R8 sticky cleared", {63'd0, ovf_sticky}, 64'd0);
    issue(2'b00, 1'b0, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, 1'b0);
    check("R8 no set without overflow", {63'd0, ovf_sticky}, 64'd0);
    // R2 in lane 7 only drives the overflow
    issue(2'b10, 1'b0, 64'h8001_0101_0101_0101, 64'h0, 1'b0);
    check("R2 lane7 result", result, 64'h7F01_0101_0101_0101);
    check("R8 set by overflow", {63'd0, ovf_sticky}, 64'd1);
    issue(2'b00, 1'b0, 64'h0, 64'h0, 1'b0);
    check("R8 kept across clean op", {63'd0, ovf_sticky}, 64'd1);
    check("R7 clean op clears op_ovf", {63'd0, op_ovf}, 64'd0);
    // R8: clear and overflowing op together leave the flag set
    issue(2'b00, 1'b1, 64'h7FFF_0000_0000_0000, 64'h0001_0000_0000_0000, 1'b1);
    check("R8 clear with overflow", {63'd0, ovf_sticky}, 64'd1);
    pulse_clear();
    check("R8 clear after collision", {63'd0, ovf_sticky}, 64'd0);
    // R6: zero opcode does not set the flag
    issue(2'b11, 1'b1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b0);
    check("R6 zero result", result, 64'd0);
    check("R6 sticky untouched", {63'd0, ovf_sticky}, 64'd0);

    // R10: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 result after reset", result, 64'd0);
    check("R10 op_ovf after reset", {63'd0, op_ovf}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule